// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This engine moves one drive transfer between a disk channel and host memory without processor help. Software builds a table of 8-byte descriptors in memory, each giving a buffer address and a byte count, with a flag on the final entry. It then writes the table's address into the pointer register and sets the start bit, choosing the direction with a second command bit. The engine fetches descriptors one at a time, in table order. In the to-memory direction it takes bytes from the drive's receive stream and writes them to consecutive buffer addresses. In the from-memory direction it reads consecutive buffer bytes and offers them on the drive's transmit stream.

The drive announces how many bytes it will move through a length input, which is sampled at start. The final status depends on how that length compares with the total the table describes. If they match, the interrupt bit is set and the active bit clears. If the table runs out first, both bits end clear. If the drive finishes first, both bits are set, and active stays set until software writes 0 to the command register. Clearing the start bit partway through ends the memory traffic for data at once. The engine still walks the table and the drive stream to settle the interrupt bit, but active stays clear.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset, all three registers read 0, no memory request is raised, the transmit stream is not valid and the receive stream is not ready.
- R2: The register port places command at offset 0 (bit 0 start, bit 3 direction: 1 means drive to memory), status at offset 2 (bit 0 active, bit 1 error which always reads 0, bit 2 interrupt) and the table pointer at offset 4. The low two bits of the pointer are ignored and read back as 0.
- R3: A descriptor is two 32-bit words: the buffer address at the entry's address, then a count word at address plus 4, read little-endian. In the count word, bits 15:0 give the byte count, where 0 means 65536, and bit 31 marks the last entry.
- R4: In the drive-to-memory direction, received bytes are written in arrival order to consecutive addresses starting at the buffer address. Each memory request holds its address until it is acknowledged.
- R5: In the memory-to-drive direction, bytes read from consecutive buffer addresses are presented on the transmit stream in order.
- R6: Descriptors are consumed in table order. The transfer continues at the next entry's buffer once the current count is used up.
- R7: When the table total equals the drive length, the final status reads 0x04.
- R8: When the last entry is used up before the drive length, the final status reads 0x00 and no further drive bytes are accepted.
- R9: When the drive length is used up before the table, the final status reads 0x05. A later write of 0 to command makes it read 0x04.
- R10: Writing 0 to command while active clears active at once and stops further data writes to memory. A long table then ends with status 0x04, and a short one ends with 0x00.
- R11: Writing 1 to status bit 2 clears the interrupt bit. Writing 0 there leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_we | input | 1 | Register write strobe |
| io_addr | input | 3 | Register offset |
| io_wdata | input | 32 | Register write data |
| io_rdata | output | 32 | Read data of the addressed register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a byte write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 32 | Read data, little-endian word at mem_addr |
| mem_ack | input | 1 | Completes the current request |
| drv_len | input | 16 | Bytes the drive will move, sampled at start |
| drv_rx_valid | input | 1 | Drive offers a byte |
| drv_rx_data | input | 8 | Byte from the drive |
| drv_rx_ready | output | 1 | Engine accepts a drive byte |
| drv_tx_valid | output | 1 | Engine offers a byte to the drive |
| drv_tx_data | output | 8 | Byte to the drive |
| drv_tx_ready | input | 1 | Drive accepts the byte |

## Verification
The hardest state to reach is a stop that lands while the engine is still in flight, before the first descriptor has been fetched. In that state, the interrupt outcome must still follow the table-versus-drive comparison, even though no data reaches memory. The stimulus issues the stop write on the register port in the cycle right after the start write. It does this for a long table in the memory-to-drive direction and for a short table in the drive-to-memory direction, and counts memory writes after the stop. A count field of zero is driven with a drive length of 32, so only the 65536 reading yields the long-table status.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
    localparam logic [2:0] REG_CMD = 3'h0;
    localparam logic [2:0] REG_STS = 3'h2;
    localparam logic [2:0] REG_PTR = 3'h4;
    localparam int CMD_GO    = 0;
    localparam int CMD_TOMEM = 3;
    localparam int STS_ACT   = 0;
    localparam int STS_IRQ   = 2;
    localparam int DESC_LAST = 31;

    typedef enum logic [2:0] {
        W_IDLE, W_FADDR, W_FCNT, W_MRD, W_TX, W_RX, W_MWR
    } walk_state_e;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_we,
    input  logic [2:0]  io_addr,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    input  logic        walk_busy,
    input  logic        ev_full,
    input  logic        ev_long,
    input  logic        ev_short,
    output logic        start_o,
    output logic        stop_o,
    output logic        dir_o,
    output logic [31:0] ptr_o
);
    typedef struct packed {
        logic        dir;
        logic        active;
        logic        intr;
        logic [31:0] ptr;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d       = q;
        start_o = 1'b0;
        stop_o  = 1'b0;
        if (io_we) begin
            case (io_addr)
                REG_CMD: begin
                    if (io_wdata[CMD_GO] && !q.active && !walk_busy) begin
                        start_o  = 1'b1;
                        d.active = 1'b1;
                        d.dir    = io_wdata[CMD_TOMEM];
                    end else if (!io_wdata[CMD_GO] && q.active) begin
                        stop_o   = 1'b1;
                        d.active = 1'b0;
                    end
                end
                REG_STS: if (io_wdata[STS_IRQ]) d.intr = 1'b0;
                REG_PTR: d.ptr = io_wdata & 32'hFFFF_FFFC;
                default: ;
            endcase
        end
        if (ev_full || ev_long) d.intr = 1'b1;
        if (ev_full || ev_short) d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (io_addr)
            REG_CMD: io_rdata = {24'd0, 4'd0, q.dir, 2'd0, q.active};
            REG_STS: io_rdata = {29'd0, q.intr, 1'b0, q.active};
            REG_PTR: io_rdata = q.ptr;
            default: io_rdata = '0;
        endcase
    end

    assign dir_o = q.dir;
    assign ptr_o = q.ptr;

    // R7
    done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_full || ev_long) |=> q.intr);
    // R8
    short_ends_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_short |=> !q.active);
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
    import sgdma_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             start_dir,
    input  logic [31:0]      tbl_ptr,
    input  logic [LEN_W-1:0] drv_len,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    output logic             busy,
    output logic             ev_full,
    output logic             ev_long,
    output logic             ev_short
);
    localparam int TC_W = CNT_W + 1;

    typedef struct packed {
        walk_state_e      st;
        logic [31:0]      dptr;
        logic [31:0]      baddr;
        logic [TC_W-1:0]  tcnt;
        logic [LEN_W-1:0] drem;
        logic             last;
        logic             dir;
        logic             drain;
        logic [7:0]       bval;
    } walk_t;

    walk_t q, d;
    logic  decide;

    always_comb begin
        d         = q;
        decide    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.baddr;
        mem_wdata = q.bval;
        rx_ready  = 1'b0;
        tx_valid  = 1'b0;
        tx_data   = q.bval;
        ev_full   = 1'b0;
        ev_long   = 1'b0;
        ev_short  = 1'b0;
        if (stop && q.st != W_IDLE) d.drain = 1'b1;
        case (q.st)
            W_IDLE: if (start) begin
                d.st    = W_FADDR;
                d.dptr  = tbl_ptr;
                d.drem  = drv_len;
                d.dir   = start_dir;
                d.drain = 1'b0;
                d.last  = 1'b0;
                d.tcnt  = '0;
            end
            W_FADDR: begin
                mem_req  = 1'b1;
                mem_addr = q.dptr;
                if (mem_ack) begin
                    d.baddr = mem_rdata;
                    d.st    = W_FCNT;
                end
            end
            W_FCNT: begin
                mem_req  = 1'b1;
                mem_addr = q.dptr + 32'd4;
                if (mem_ack) begin
                    if (mem_rdata[CNT_W-1:0] == '0) d.tcnt = TC_W'(1) << CNT_W;
                    else                            d.tcnt = TC_W'(mem_rdata[CNT_W-1:0]);
                    d.last = mem_rdata[DESC_LAST];
                    d.dptr = q.dptr + 32'd8;
                    decide = 1'b1;
                end
            end
            W_MRD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    d.bval = mem_rdata[7:0];
                    d.st   = W_TX;
                end
            end
            W_TX: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    d.tcnt  = q.tcnt - TC_W'(1);
                    d.drem  = q.drem - LEN_W'(1);
                    d.baddr = q.baddr + 32'd1;
                    decide  = 1'b1;
                end
            end
            W_RX: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.bval = rx_data;
                    d.tcnt = q.tcnt - TC_W'(1);
                    d.drem = q.drem - LEN_W'(1);
                    if (d.drain) begin
                        d.baddr = q.baddr + 32'd1;
                        decide  = 1'b1;
                    end else begin
                        d.st = W_MWR;
                    end
                end
            end
            W_MWR: begin
                if (q.drain) begin
                    d.baddr = q.baddr + 32'd1;
                    decide  = 1'b1;
                end else begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                    if (mem_ack) begin
                        d.baddr = q.baddr + 32'd1;
                        decide  = 1'b1;
                    end
                end
            end
            default: d.st = W_IDLE;
        endcase

        if (decide) begin
            if (d.drem == '0) begin
                if (d.tcnt == '0 && d.last) ev_full = 1'b1;
                else                        ev_long = 1'b1;
                d.st = W_IDLE;
            end else if (d.tcnt == '0) begin
                if (d.last) begin
                    ev_short = 1'b1;
                    d.st     = W_IDLE;
                end else begin
                    d.st = W_FADDR;
                end
            end else if (d.dir) begin
                d.st = W_RX;
            end else if (d.drain) begin
                d.bval = 8'd0;
                d.st   = W_TX;
            end else begin
                d.st = W_MRD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.st != W_IDLE);

    // R4
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !stop) |=> (mem_req && $stable(mem_addr)));
    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_full, ev_long, ev_short}));
    // R10
    no_write_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.drain |-> !(mem_req && mem_we));
    // R5
    one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sgdma_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_we,
    input  logic [2:0]       io_addr,
    input  logic [31:0]      io_wdata,
    output logic [31:0]      io_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    input  logic [LEN_W-1:0] drv_len,
    input  logic             drv_rx_valid,
    input  logic [7:0]       drv_rx_data,
    output logic             drv_rx_ready,
    output logic             drv_tx_valid,
    output logic [7:0]       drv_tx_data,
    input  logic             drv_tx_ready
);
    logic        start, stop, dir, busy;
    logic        ev_full, ev_long, ev_short;
    logic [31:0] ptr;

    sgdma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_we     (io_we),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .walk_busy (busy),
        .ev_full   (ev_full),
        .ev_long   (ev_long),
        .ev_short  (ev_short),
        .start_o   (start),
        .stop_o    (stop),
        .dir_o     (dir),
        .ptr_o     (ptr)
    );

    sgdma_walker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .start_dir (io_wdata[CMD_TOMEM]),
        .tbl_ptr   (ptr),
        .drv_len   (drv_len),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .rx_valid  (drv_rx_valid),
        .rx_data   (drv_rx_data),
        .rx_ready  (drv_rx_ready),
        .tx_valid  (drv_tx_valid),
        .tx_data   (drv_tx_data),
        .tx_ready  (drv_tx_ready),
        .busy      (busy),
        .ev_full   (ev_full),
        .ev_long   (ev_long),
        .ev_short  (ev_short)
    );

    // R2
    dir_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> $stable(dir));
endmodule

// File: tb/sim_sg_dma_engine.sv
`timescale 1ns/1ps
module sim_sg_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_we = 1'b0;
    logic [2:0]  io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] drv_len = '0;
    logic        drv_rx_valid = 1'b0;
    logic [7:0]  drv_rx_data = '0;
    logic        drv_rx_ready;
    logic        drv_tx_valid;
    logic [7:0]  drv_tx_data;
    logic        drv_tx_ready = 1'b1;

    always #2 clk = ~clk;

    sg_dma_engine u0 (.*);

    logic [7:0] mem [0:4095];
    logic [7:0] src [0:255];
    logic [7:0] sink [0:255];
    int rx_idx = 0, rx_total = 0, sink_n = 0, wr_count = 0;
    bit rx_fire = 1'b0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // memory and drive stream models, all driven at the falling edge
    always @(negedge clk) begin
        if (rx_fire) rx_idx++;
        if (drv_tx_valid && drv_tx_ready && sink_n < 256) begin
            sink[sink_n] = drv_tx_data;
            sink_n++;
        end
        mem_ack = mem_req;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] = mem_wdata;
                wr_count++;
            end
            mem_rdata = {mem[mem_addr[11:0] + 12'd3], mem[mem_addr[11:0] + 12'd2],
                         mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
        end
        drv_rx_valid = (rx_idx < rx_total);
        drv_rx_data  = src[rx_idx[7:0]];
        rx_fire      = drv_rx_valid && drv_rx_ready;
    end

    typedef struct packed {
        logic        dir;
        logic        two;
        logic [15:0] c0;
        logic [15:0] c1;
        logic [15:0] dlen;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 16'd64,  16'd0,   16'd64, 8'h04},
        '{1'b0, 1'b0, 16'd64,  16'd0,   16'd64, 8'h04},
        '{1'b1, 1'b1, 16'd20,  16'd44,  16'd64, 8'h04},
        '{1'b0, 1'b1, 16'd30,  16'd34,  16'd64, 8'h04},
        '{1'b1, 1'b0, 16'd16,  16'd0,   16'd64, 8'h00},
        '{1'b0, 1'b0, 16'd200, 16'd0,   16'd64, 8'h05},
        '{1'b1, 1'b1, 16'd10,  16'd10,  16'd64, 8'h00},
        '{1'b0, 1'b1, 16'd40,  16'd100, 16'd64, 8'h05}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        io_we = 1'b1; io_addr = a; io_wdata = v;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic io_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        io_addr = a;
        #1 v = io_rdata;
    endtask

    function automatic logic [11:0] baddr(input int j, input int c0e);
        return (j < c0e) ? 12'(32'h200 + j) : 12'(32'h400 + (j - c0e));
    endfunction

    task automatic prepare(input logic dir, input logic two, input logic [15:0] c0,
                           input logic [15:0] c1, input logic [15:0] dlen, input int seed);
        logic [31:0] w1, w3;
        io_write(3'h0, 32'h0);
        io_write(3'h2, 32'h4);
        w1 = {!two, 15'd0, c0};
        w3 = {1'b1, 15'd0, c1};
        for (int b = 0; b < 4; b++) begin
            mem[12'h100 + 12'(b)] = 8'(32'h200 >> (8 * b));
            mem[12'h104 + 12'(b)] = w1[8*b +: 8];
            mem[12'h108 + 12'(b)] = 8'(32'h400 >> (8 * b));
            mem[12'h10C + 12'(b)] = w3[8*b +: 8];
        end
        for (int j = 0; j < 256; j++) begin
            mem[12'h200 + 12'(j)] = dir ? 8'h00 : 8'(j * 5 + seed);
            mem[12'h400 + 12'(j)] = dir ? 8'h00 : 8'(j * 11 + seed);
            src[j] = 8'(j * 7 + seed + 1);
        end
        rx_idx = 0; rx_total = dir ? int'(dlen) : 0; sink_n = 0; wr_count = 0;
        drv_len = dlen;
        io_write(3'h4, 32'h100);
    endtask

    task automatic run_case(input logic dir, input logic two, input logic [15:0] c0,
                            input logic [15:0] c1, input logic [15:0] dlen,
                            input logic [7:0] exp, input string stag, input int seed);
        logic [31:0] s;
        int c0e, tot, moved, bad;
        string dtag;
        c0e = (c0 == 0) ? 65536 : int'(c0);
        tot = c0e + (two ? int'(c1) : 0);
        moved = (tot < int'(dlen)) ? tot : int'(dlen);
        dtag = two ? "R6" : (dir ? "R4" : "R5");
        prepare(dir, two, c0, c1, dlen, seed);
        io_write(3'h0, dir ? 32'h9 : 32'h1);
        for (int k = 0; k < 4000; k++) begin
            io_read(3'h2, s);
            if (!s[0] || s[2]) break;
        end
        check(s[7:0] == exp, stag, s, {24'd0, exp});
        bad = 0;
        if (dir) begin
            for (int j = 0; j < moved; j++)
                if (mem[baddr(j, c0e)] !== src[j]) bad++;
            check(rx_idx == moved, dtag, rx_idx, moved);
        end else begin
            for (int j = 0; j < moved; j++)
                if (sink[j] !== mem[baddr(j, c0e)]) bad++;
            check(sink_n == moved, dtag, sink_n, moved);
        end
        check(bad == 0, dtag, bad, 0);
        if (exp[0]) begin
            io_write(3'h0, 32'h0);
            io_read(3'h2, s);
            check(s[7:0] == 8'h04, "R9", s, 32'h4);
        end
        if (exp[2]) begin
            io_write(3'h2, 32'h0);
            io_read(3'h2, s);
            check(s[2] == 1'b1, "R11", s, 32'h4);
            io_write(3'h2, 32'h4);
            io_read(3'h2, s);
            check(s[7:0] == 8'h00, "R11", s, 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        string tag;
        for (int j = 0; j < 4096; j++) mem[j] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        io_read(3'h2, s); check(s == 0, "R1", s, 0);
        io_read(3'h4, s); check(s == 0, "R1", s, 0);
        io_read(3'h0, s); check(s == 0, "R1", s, 0);
        check(!mem_req && !drv_tx_valid && !drv_rx_ready, "R1",
              {mem_req, drv_tx_valid, drv_rx_ready}, 0);

        // R2 pointer alignment
        io_write(3'h4, 32'h0000_0123);
        io_read(3'h4, s); check(s == 32'h120, "R2", s, 32'h120);

        // vector table: R7 match, R8 short, R9 long
        for (int i = 0; i < 8; i++) begin
            tag = (VECS[i].exp == 8'h04) ? "R7" : ((VECS[i].exp == 8'h00) ? "R8" : "R9");
            run_case(VECS[i].dir, VECS[i].two, VECS[i].c0, VECS[i].c1,
                     VECS[i].dlen, VECS[i].exp, tag, i + 3);
        end

        // R3 count of zero means 65536: long outcome for a 32-byte drive
        run_case(1'b1, 1'b0, 16'd0, 16'd0, 16'd32, 8'h05, "R3", 40);

        // R10 stop right after start, long table
        prepare(1'b0, 1'b0, 16'd200, 16'd0, 16'd64, 50);
        io_write(3'h0, 32'h1);
        io_write(3'h0, 32'h0);
        io_read(3'h2, s); check(s[7:0] == 8'h00, "R10", s, 0);
        for (int k = 0; k < 4000; k++) begin
            io_read(3'h2, s);
            if (s[2]) break;
        end
        check(s[7:0] == 8'h04, "R10", s, 32'h4);
        io_write(3'h2, 32'h4);

        // R10 stop right after start, short table
        prepare(1'b1, 1'b0, 16'd16, 16'd0, 16'd64, 60);
        io_write(3'h0, 32'h9);
        io_write(3'h0, 32'h0);
        repeat (300) @(negedge clk);
        io_read(3'h2, s); check(s[7:0] == 8'h00, "R10", s, 0);
        check(wr_count == 0, "R10", wr_count, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule